// File: doc/BRIEF.md
# Power-up Strap Sampler with Test-Point Debug Driver

This block shares eleven pads between two uses. While reset is held, every pad is an input, its driver off, so board-level pull resistors and jumpers set a level on it. A fixed number of clock cycles after reset is released, the block captures all pads in one cycle. It then turns them into outputs. The eight test-point pads give a configuration word that the rest of the chip reads until the next reset. The three select pads give a code that decides what the test-point pads drive from then on.

With the select code 3'b010, the test-point pads carry clock-debug signals. These are a gated copy of the core clock, three divided clocks at one half, one quarter and one eighth of its rate, and several static lows. With any other code, including the 3'b111 that idle pull-ups give, the test-point drivers stay off. Each pad is shown as separate input, output and output-enable signals.

Top module: `strap_capture_dbgmux`

## Requirements
- R1: While rst_n is low, tp_oe and sel_oe are all zero, straps_valid is 0 and cfg_word is 0.
- R2: The pads are captured at exactly the SAMPLE_DELAY-th rising clock edge after rst_n goes high (default 90, which is 1.5 µs at 60 MHz). straps_valid becomes 1 just after that edge and not earlier.
- R3: cfg_word equals the tp_in value present at the capture edge. It keeps that value, and straps_valid stays 1, whatever tp_in does until the next reset.
- R4: After capture, sel_oe is 3'b111 and sel_out drives the captured select value.
- R5: When the captured select value equals DEBUG_CODE (3'b010), all eight tp_oe bits are 1 after capture.
- R6: In debug mode, test-point pins 3, 6 and 7 drive 0. Pins 0 and 5 drive the clock: 0 while clk is low and 1 while clk is high, starting from the first full clock cycle after capture.
- R7: A divider counts rising edges from reset release, starting at 0. After edge k, in debug mode, pin 1 shows bit 0 of k, pin 4 shows bit 1 and pin 2 shows bit 2. These are the clock divided by 2, 4 and 8.
- R8: For any captured select value other than DEBUG_CODE (for example 3'b111 or 3'b110), all tp_oe bits stay 0 after capture.
- R9: A new reset returns the block to the R1 state, and the following capture takes fresh pad values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock (60 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| tp_in | input | 8 | Test-point pad input levels |
| tp_out | output | 8 | Test-point pad output levels |
| tp_oe | output | 8 | Test-point pad driver enables |
| sel_in | input | 3 | Select pad input levels |
| sel_out | output | 3 | Select pad output levels (captured code) |
| sel_oe | output | 3 | Select pad driver enables |
| cfg_word | output | 8 | Captured configuration word |
| straps_valid | output | 1 | High from the cycle after capture until reset |

## Verification
A delay counter that is off by one moves the rise of straps_valid, so it shows at the capture cycle itself. It also makes cfg_word take the neighbouring tp_in value, which the bench changes on purpose one cycle before the capture edge. A wrong captured code or a wrong mode decode makes tp_oe differ within one cycle of capture. A divider that is out of phase or has the wrong taps shows on pins 1, 2 and 4 within eight cycles, because the bench predicts each level from its own count of rising edges since reset.

// File: rtl/strap_pkg.sv
package strap_pkg;
   localparam int TP_PINS = 8;

   typedef enum logic [2:0] {
      SRC_LOW,
      SRC_CLK,
      SRC_DIV2,
      SRC_DIV4,
      SRC_DIV8
   } tp_src_e;

   // fixed debug pattern per test-point pin
   function automatic tp_src_e debug_source(input int pin);
      case (pin)
         0, 5:    return SRC_CLK;
         1:       return SRC_DIV2;
         2:       return SRC_DIV8;
         4:       return SRC_DIV4;
         default: return SRC_LOW;
      endcase
   endfunction

   // divider bit that produces a divided source
   function automatic int div_tap(input tp_src_e src);
      case (src)
         SRC_DIV4: return 1;
         SRC_DIV8: return 2;
         default:  return 0;
      endcase
   endfunction
endpackage

// File: rtl/strap_delay_timer.sv
module strap_delay_timer #(
   parameter int SAMPLE_DELAY = 90
) (
   input  logic clk,
   input  logic rst_n,
   output logic sample_now,
   output logic done
);
   localparam int CW = $clog2(SAMPLE_DELAY + 1);

   logic [CW-1:0] cnt;

   assign sample_now = !done && (cnt == CW'(SAMPLE_DELAY - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (!done) begin
         cnt <= cnt + 1'b1;
         if (sample_now) done <= 1'b1;
      end
   end
endmodule

// File: rtl/strap_latch.sv
module strap_latch #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end
endmodule

// File: rtl/dbg_clk_divider.sv
module dbg_clk_divider #(
   parameter int STAGES = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [STAGES-1:0] div
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div <= '0;
      else        div <= div + 1'b1;
   end
endmodule

// File: rtl/dbg_pin_mux.sv
module dbg_pin_mux
   import strap_pkg::*;
#(
   parameter int PINS   = 8,
   parameter int STAGES = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dbg_en,
   input  logic [STAGES-1:0] div,
   output logic [PINS-1:0]   pin_out
);
   // enable for the clock gate changes only while clk is low
   logic gate_en;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) gate_en <= 1'b0;
      else        gate_en <= dbg_en;
   end

   for (genvar i = 0; i < PINS; i++) begin : g_pin
      localparam tp_src_e SRC = debug_source(i);
      if (SRC == SRC_CLK) begin : g_clk
         assign pin_out[i] = clk & gate_en;
      end else if (SRC == SRC_LOW) begin : g_low
         assign pin_out[i] = 1'b0;
      end else begin : g_div
         assign pin_out[i] = div[div_tap(SRC)];
      end
   end
endmodule

// File: rtl/strap_capture_dbgmux.sv
module strap_capture_dbgmux #(
   parameter int         TP_W         = 8,
   parameter int         SEL_W        = 3,
   parameter int         SAMPLE_DELAY = 90,
   parameter int         DIV_STAGES   = 3,
   parameter logic [2:0] DEBUG_CODE   = 3'b010
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TP_W-1:0]  tp_in,
   output logic [TP_W-1:0]  tp_out,
   output logic [TP_W-1:0]  tp_oe,
   input  logic [SEL_W-1:0] sel_in,
   output logic [SEL_W-1:0] sel_out,
   output logic [SEL_W-1:0] sel_oe,
   output logic [TP_W-1:0]  cfg_word,
   output logic             straps_valid
);
   if (TP_W != strap_pkg::TP_PINS) begin : g_bad_width
      $error("TP_W must match the fixed debug pattern width");
   end
   if (SEL_W != 3) begin : g_bad_sel
      $error("SEL_W must be 3");
   end
   if (SAMPLE_DELAY < 2) begin : g_bad_delay
      $error("SAMPLE_DELAY must be at least 2");
   end
   if (DIV_STAGES < 3) begin : g_bad_div
      $error("DIV_STAGES must cover the divide-by-8 tap");
   end

   logic                  sample_now;
   logic                  done;
   logic [SEL_W-1:0]      sel_q;
   logic [TP_W-1:0]       tp_q;
   logic [DIV_STAGES-1:0] div;
   logic                  dbg_en;

   strap_delay_timer #(.SAMPLE_DELAY(SAMPLE_DELAY)) u_timer (
      .clk(clk), .rst_n(rst_n), .sample_now(sample_now), .done(done)
   );

   strap_latch #(.W(TP_W)) u_tp_latch (
      .clk(clk), .rst_n(rst_n), .load(sample_now), .d(tp_in), .q(tp_q)
   );

   strap_latch #(.W(SEL_W)) u_sel_latch (
      .clk(clk), .rst_n(rst_n), .load(sample_now), .d(sel_in), .q(sel_q)
   );

   dbg_clk_divider #(.STAGES(DIV_STAGES)) u_div (
      .clk(clk), .rst_n(rst_n), .div(div)
   );

   assign dbg_en = done && (sel_q == DEBUG_CODE);

   dbg_pin_mux #(.PINS(TP_W), .STAGES(DIV_STAGES)) u_mux (
      .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .div(div), .pin_out(tp_out)
   );

   assign tp_oe        = {TP_W{dbg_en}};
   assign sel_oe       = {SEL_W{done}};
   assign sel_out      = sel_q;
   assign cfg_word     = tp_q;
   assign straps_valid = done;
endmodule

// File: rtl/strap_capture_chk.sv
module strap_capture_chk #(
   parameter int         TP_W         = 8,
   parameter int         SEL_W        = 3,
   parameter int         SAMPLE_DELAY = 90,
   parameter logic [2:0] DEBUG_CODE   = 3'b010
) (
   input logic             clk,
   input logic             rst_n,
   input logic [TP_W-1:0]  tp_in,
   input logic [TP_W-1:0]  tp_out,
   input logic [TP_W-1:0]  tp_oe,
   input logic [SEL_W-1:0] sel_out,
   input logic [SEL_W-1:0] sel_oe,
   input logic [TP_W-1:0]  cfg_word,
   input logic             straps_valid
);
   int unsigned cyc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cyc <= 0;
      else if (cyc < 32'h7fff_ffff) cyc <= cyc + 1;
   end

   assert_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(straps_valid) |-> cyc == SAMPLE_DELAY);

   assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(straps_valid) |-> cfg_word == $past(tp_in));

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      straps_valid |=> straps_valid && $stable(cfg_word) && $stable(sel_out));

   assert_quiet_before_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !straps_valid |-> tp_oe == '0 && sel_oe == '0);

   assert_sel_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      straps_valid |-> sel_oe == '1);

   assert_debug_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      straps_valid && sel_out == DEBUG_CODE |-> tp_oe == '1);

   assert_idle_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      straps_valid && sel_out != DEBUG_CODE |-> tp_oe == '0);

   assert_static_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tp_oe[3] |-> !tp_out[3] && !tp_out[6] && !tp_out[7]);

   assert_div2_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tp_oe[1] && $past(tp_oe[1]) |-> tp_out[1] != $past(tp_out[1]));
endmodule

bind strap_capture_dbgmux strap_capture_chk #(
   .TP_W(TP_W), .SEL_W(SEL_W), .SAMPLE_DELAY(SAMPLE_DELAY), .DEBUG_CODE(DEBUG_CODE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tp_in(tp_in), .tp_out(tp_out), .tp_oe(tp_oe),
   .sel_out(sel_out), .sel_oe(sel_oe), .cfg_word(cfg_word),
   .straps_valid(straps_valid)
);

// File: tb/sim_strap_capture_dbgmux.sv
module sim_strap_capture_dbgmux;
   localparam int CLK_PERIOD = 16;
   localparam int DELAY      = 90;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] tp_in = '0;
   logic [2:0] sel_in = 3'b111;
   logic [7:0] tp_out, tp_oe, cfg_word;
   logic [2:0] sel_out, sel_oe;
   logic       straps_valid;

   int n_checks = 0;
   int n_fail   = 0;
   int edges    = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   // rising edges since reset release (bench's own count)
   always @(posedge clk) begin
      if (!rst_n) edges <= 0;
      else        edges <= edges + 1;
   end

   strap_capture_dbgmux u0 (
      .clk(clk), .rst_n(rst_n), .tp_in(tp_in), .tp_out(tp_out), .tp_oe(tp_oe),
      .sel_in(sel_in), .sel_out(sel_out), .sel_oe(sel_oe),
      .cfg_word(cfg_word), .straps_valid(straps_valid)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      tp_in = 8'($urandom);
      sel_in = 3'b010;
      repeat (4) @(negedge clk);
      // R1 / R9: pads released and outputs cleared during reset
      chk("R1 tp_oe", tp_oe, 0);
      chk("R1 sel_oe", sel_oe, 0);
      chk("R1 straps_valid", straps_valid, 0);
      chk("R9 cfg_word", cfg_word, 0);
   endtask

   task automatic do_capture(input logic [7:0] tpv, input logic [2:0] selv);
      tp_in  = ~tpv;
      sel_in = ~selv;
      rst_n  = 1'b1;
      while (edges != DELAY - 1) @(negedge clk);
      chk("R2 not yet valid", straps_valid, 0);
      chk("R2 not yet driving", sel_oe, 0);
      tp_in  = tpv;
      sel_in = selv;
      @(negedge clk);
      chk("R2 valid after capture edge", straps_valid, 1);
      chk("R3 cfg_word", cfg_word, tpv);
      chk("R4 sel_oe", sel_oe, 3'b111);
      chk("R4 sel_out", sel_out, selv);
      tp_in  = 8'($urandom);
      sel_in = 3'($urandom);
      repeat (5) @(negedge clk);
      chk("R3 cfg_word held", cfg_word, tpv);
      chk("R3 straps_valid held", straps_valid, 1);
   endtask

   task automatic test_debug();
      for (int n = 0; n < 16; n++) begin
         @(negedge clk);
         chk("R5 tp_oe", tp_oe, 8'hff);
         chk("R6 lows", {tp_out[7], tp_out[6], tp_out[3]}, 0);
         chk("R6 clk pins low phase", {tp_out[5], tp_out[0]}, 0);
         chk("R7 div2 pin1", tp_out[1], edges % 2);
         chk("R7 div4 pin4", tp_out[4], (edges / 2) % 2);
         chk("R7 div8 pin2", tp_out[2], (edges / 4) % 2);
         @(posedge clk);
         #1;
         chk("R6 clk pins high phase", {tp_out[5], tp_out[0]}, 3);
      end
   endtask

   task automatic test_quiet(input string tag);
      for (int n = 0; n < 8; n++) begin
         @(negedge clk);
         chk(tag, tp_oe, 0);
      end
   endtask

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      do_reset();
      v = 8'($urandom);
      do_capture(v, 3'b010);
      test_debug();

      do_reset();
      v = 8'($urandom);
      do_capture(v, 3'b111);
      test_quiet("R8 default code 111");

      do_reset();
      v = 8'($urandom);
      do_capture(v, 3'b110);
      test_quiet("R8 other code 110");

      do_reset();
      do_capture(8'ha5, 3'b010);
      test_debug();
      do_reset();

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule